// File: doc/BRIEF.md
# Indexed Socket Register Port

This block gives a host access to a bank of 8-bit control registers for up to four card sockets through only two host addresses. The host first writes a register index to the index address (address 0). It then reads or writes the selected register through the data address (address 1). The upper index bits select the socket and the lower six bits select the register inside that socket, so socket n owns indices n*64 to n*64+63. A 2-bit configuration input sets how many sockets exist. Data accesses aimed at a socket beyond that count are inert.

Every data access to a configured socket returns a one-cycle strobe to the socket logic. The strobe carries the socket number and the local register number, so that neighbouring logic can clear state on a read or act on a write. Local register 1 of each socket is a read-only status byte driven by the socket logic. A per-socket card-present flag is derived from that byte. Wider values are written as byte pairs at consecutive indices. The index never advances by itself, so a read-modify-write can re-send the same index before it writes the data back.

Top module: `sock_index_port`

## Requirements
- R1: A write with hostAddr=0 loads hostWdata into the index register. A read with hostAddr=0 returns the index on hostRdata one clock after the read request.
- R2: The index decodes as socket = index[7:6] and local register = index[5:0]. A data write (hostAddr=1) to a configured socket stores hostWdata in that register only. A data read returns that value one clock after the request.
- R3: sockCfg selects the number of configured sockets: 2'b00 gives two (sockets 0–1), 2'b01 gives one (socket 0), and 2'b10 or 2'b11 gives four.
- R4: A data access whose socket number is not configured reads back 0x00. It leaves every register unchanged and raises no strobe.
- R5: Data accesses never change the index register. Only a write with hostAddr=0 changes it.
- R6: A 16-bit value written as a low byte at index k and a high byte at index k+1 is held in those two registers. Neighbouring indices are not disturbed.
- R7: Local register 1 reads back the socket's status byte from sockStatus[s*8 +: 8], and writes to it do not store. cardPresent[s] is 1 only when socket s is configured and bits 2 and 3 of its status byte are both 1.
- R8: A data read of a configured socket raises rdStrobe for exactly one clock, in the same cycle as the returned data. strobeSock and strobeReg carry that socket and local register number.
- R9: A data write to a configured socket raises wrStrobe for exactly one clock, in the cycle after the request. strobeSock and strobeReg carry the socket and local register number.
- R10: After reset, every register, the index, hostRdata and both strobes are 0.
- R11: When hostWr and hostRd are both high, the write is performed and the read is dropped. hostRdata then holds its value and rdStrobe stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write request, one access per cycle high |
| hostRd | input | 1 | Host read request, one access per cycle high |
| hostAddr | input | 1 | 0 selects the index address, 1 selects the data address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Registered read data, valid the cycle after a read |
| sockCfg | input | 2 | Socket count selection |
| sockStatus | input | 32 | Status byte of each socket, socket s at bits s*8+7..s*8 |
| cardPresent | output | 4 | Card-present flag per socket |
| rdStrobe | output | 1 | One-cycle pulse after a data read of a configured socket |
| wrStrobe | output | 1 | One-cycle pulse after a data write to a configured socket |
| strobeSock | output | 2 | Socket number of the last strobed access |
| strobeReg | output | 6 | Local register number of the last strobed access |

## Verification
The index register, hostRdata, rdStrobe and wrStrobe all change at the first rising edge after the request cycle. cardPresent follows sockStatus and sockCfg within the same cycle. The bench changes inputs on the falling edge and holds a request for exactly one cycle. It samples registered results at the next falling edge, and samples cardPresent shortly after it changes the inputs. Strobe width is checked one further falling edge later. The main sweep writes and reads back all 256 indices under each of the four configurations, with expected values computed from the index arithmetic.

// File: rtl/sock_index_port_pkg.sv
package sock_index_port_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic idxLoad;
    logic idxRead;
    logic dataRead;
    logic dataWrite;
    logic sockOk;
  } portCtl_t;

  localparam int STATUS_LREG = 1;
  localparam int PRESENT_BIT_A = 2;
  localparam int PRESENT_BIT_B = 3;

  // Configured socket count selected by the 2-bit field.
  function automatic logic [2:0] sockCount(input logic [1:0] cfg);
    case (cfg)
      2'b00:   sockCount = 3'd2;
      2'b01:   sockCount = 3'd1;
      default: sockCount = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/sock_index_port_ctrl.sv
module sock_index_port_ctrl
  import sock_index_port_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int LREG_W   = 6,
  parameter int DATA_W   = 8,
  localparam int SOCK_W  = $clog2(NUM_SOCK),
  localparam int CNT_W   = SOCK_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostAddr,
  input  logic [1:0]        sockCfg,
  input  logic [DATA_W-1:0] idxQ,
  output portCtl_t          ctl,
  output logic [SOCK_W-1:0] sock,
  output logic [LREG_W-1:0] lreg,
  output logic [NUM_SOCK-1:0] sockEn,
  output logic              rdStrobe,
  output logic              wrStrobe,
  output logic [SOCK_W-1:0] strobeSock,
  output logic [LREG_W-1:0] strobeReg
);

  logic [2:0]       rawCnt;
  logic [CNT_W-1:0] cnt;
  logic             wrAcc;
  logic             rdAcc;

  assign rawCnt = sockCount(sockCfg);
  assign cnt    = (int'(rawCnt) > NUM_SOCK) ? CNT_W'(NUM_SOCK) : CNT_W'(rawCnt);

  // Fixed stride decode: upper bits socket, lower bits local register.
  assign sock = idxQ[LREG_W +: SOCK_W];
  assign lreg = idxQ[LREG_W-1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_SOCK; g++) begin : gEn
      assign sockEn[g] = (CNT_W'(g) < cnt);
    end
  endgenerate

  // Write wins when both requests are raised.
  assign wrAcc = hostWr;
  assign rdAcc = hostRd & ~hostWr;

  always_comb begin
    ctl.sockOk    = ({1'b0, sock} < cnt);
    ctl.idxLoad   = wrAcc & ~hostAddr;
    ctl.idxRead   = rdAcc & ~hostAddr;
    ctl.dataRead  = rdAcc & hostAddr;
    ctl.dataWrite = wrAcc & hostAddr & ctl.sockOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdStrobe   <= 1'b0;
      wrStrobe   <= 1'b0;
      strobeSock <= '0;
      strobeReg  <= '0;
    end else begin
      rdStrobe <= ctl.dataRead & ctl.sockOk;
      wrStrobe <= ctl.dataWrite;
      if ((ctl.dataRead & ctl.sockOk) | ctl.dataWrite) begin
        strobeSock <= sock;
        strobeReg  <= lreg;
      end
    end
  end

endmodule

// File: rtl/sock_index_port_dp.sv
module sock_index_port_dp
  import sock_index_port_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int LREG_W   = 6,
  parameter int DATA_W   = 8,
  localparam int SOCK_W  = $clog2(NUM_SOCK),
  localparam int REGS    = 1 << LREG_W,
  localparam int DEPTH   = NUM_SOCK * REGS,
  localparam int ADDR_W  = SOCK_W + LREG_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  portCtl_t                   ctl,
  input  logic [SOCK_W-1:0]          sock,
  input  logic [LREG_W-1:0]          lreg,
  input  logic [NUM_SOCK-1:0]        sockEn,
  input  logic [DATA_W-1:0]          hostWdata,
  input  logic [NUM_SOCK*DATA_W-1:0] sockStatus,
  output logic [DATA_W-1:0]          idxQ,
  output logic [DATA_W-1:0]          hostRdata,
  output logic [NUM_SOCK-1:0]        cardPresent
);

  logic [DATA_W-1:0] regBank [DEPTH];
  logic [DATA_W-1:0] statusArr [NUM_SOCK];
  logic [ADDR_W-1:0] bankAddr;
  logic              isStatus;
  logic [DATA_W-1:0] rdNext;

  assign bankAddr = {sock, lreg};
  assign isStatus = (lreg == LREG_W'(STATUS_LREG));

  genvar g;
  generate
    for (g = 0; g < NUM_SOCK; g++) begin : gSock
      assign statusArr[g]   = sockStatus[g*DATA_W +: DATA_W];
      assign cardPresent[g] = sockEn[g] & statusArr[g][PRESENT_BIT_A]
                                        & statusArr[g][PRESENT_BIT_B];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
    end else if (ctl.idxLoad) begin
      idxQ <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regBank[i] <= '0;
    end else if (ctl.dataWrite && !isStatus) begin
      regBank[bankAddr] <= hostWdata;
    end
  end

  always_comb begin
    rdNext = hostRdata;
    if (ctl.idxRead) begin
      rdNext = idxQ;
    end else if (ctl.dataRead) begin
      if (!ctl.sockOk)    rdNext = '0;
      else if (isStatus)  rdNext = statusArr[sock];
      else                rdNext = regBank[bankAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) hostRdata <= '0;
    else       hostRdata <= rdNext;
  end

endmodule

// File: rtl/sock_index_port.sv
module sock_index_port
  import sock_index_port_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int LREG_W   = 6,
  parameter int DATA_W   = 8,
  localparam int SOCK_W  = $clog2(NUM_SOCK)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWr,
  input  logic                       hostRd,
  input  logic                       hostAddr,
  input  logic [DATA_W-1:0]          hostWdata,
  output logic [DATA_W-1:0]          hostRdata,
  input  logic [1:0]                 sockCfg,
  input  logic [NUM_SOCK*DATA_W-1:0] sockStatus,
  output logic [NUM_SOCK-1:0]        cardPresent,
  output logic                       rdStrobe,
  output logic                       wrStrobe,
  output logic [SOCK_W-1:0]          strobeSock,
  output logic [LREG_W-1:0]          strobeReg
);

  portCtl_t            ctl;
  logic [DATA_W-1:0]   idxQ;
  logic [SOCK_W-1:0]   sock;
  logic [LREG_W-1:0]   lreg;
  logic [NUM_SOCK-1:0] sockEn;

  sock_index_port_ctrl #(.NUM_SOCK(NUM_SOCK), .LREG_W(LREG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .sockCfg(sockCfg), .idxQ(idxQ), .ctl(ctl), .sock(sock), .lreg(lreg),
    .sockEn(sockEn), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe),
    .strobeSock(strobeSock), .strobeReg(strobeReg)
  );

  sock_index_port_dp #(.NUM_SOCK(NUM_SOCK), .LREG_W(LREG_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sock(sock), .lreg(lreg), .sockEn(sockEn),
    .hostWdata(hostWdata), .sockStatus(sockStatus), .idxQ(idxQ),
    .hostRdata(hostRdata), .cardPresent(cardPresent)
  );

endmodule

// File: rtl/sock_index_port_chk.sv
module sock_index_port_chk #(
  parameter int NUM_SOCK = 4,
  parameter int LREG_W   = 6,
  parameter int DATA_W   = 8,
  localparam int SOCK_W  = $clog2(NUM_SOCK)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       hostWr,
  input logic                       hostRd,
  input logic                       hostAddr,
  input logic [DATA_W-1:0]          hostWdata,
  input logic [DATA_W-1:0]          hostRdata,
  input logic [1:0]                 sockCfg,
  input logic [NUM_SOCK*DATA_W-1:0] sockStatus,
  input logic [NUM_SOCK-1:0]        cardPresent,
  input logic                       rdStrobe,
  input logic                       wrStrobe,
  input logic [DATA_W-1:0]          idxQ
);

  int                  cfgCnt;
  logic                idxUncfg;
  logic [NUM_SOCK-1:0] presentOk;

  always_comb begin
    cfgCnt = (sockCfg == 2'b00) ? 2 : (sockCfg == 2'b01) ? 1 : 4;
    if (cfgCnt > NUM_SOCK) cfgCnt = NUM_SOCK;
    idxUncfg = (int'(idxQ[LREG_W +: SOCK_W]) >= cfgCnt);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_SOCK; g++) begin : gPres
      assign presentOk[g] = (g < cfgCnt) && sockStatus[g*DATA_W + 2] && sockStatus[g*DATA_W + 3];
    end
  endgenerate

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostAddr) |=> (idxQ == $past(hostWdata))); // R1

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && !hostAddr) |=> $stable(idxQ)); // R5

  AST_UNCFG_READ: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostWr && hostAddr && idxUncfg) |=> (hostRdata == '0 && !rdStrobe)); // R4

  AST_UNCFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && idxUncfg) |=> !wrStrobe); // R4

  AST_PRESENT: assert property (@(posedge clk) disable iff (!rstN)
    (cardPresent & ~presentOk) == '0); // R7

  AST_ONE_SOCK: assert property (@(posedge clk) disable iff (!rstN)
    (sockCfg == 2'b01) |-> (cardPresent[NUM_SOCK-1:1] == '0)); // R3

  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |-> $past(hostRd && !hostWr && hostAddr)); // R8

  AST_WR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(hostWr && hostAddr)); // R9

  AST_WR_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostRd) |=> (!rdStrobe && $stable(hostRdata))); // R11

endmodule

bind sock_index_port sock_index_port_chk #(
  .NUM_SOCK(NUM_SOCK), .LREG_W(LREG_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sock_index_port_tb.sv
`timescale 1ns/1ps
module sock_index_port_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic        hostAddr = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic [1:0]  sockCfg = 2'b10;
  logic [31:0] sockStatus = '0;
  logic [3:0]  cardPresent;
  logic        rdStrobe;
  logic        wrStrobe;
  logic [1:0]  strobeSock;
  logic [5:0]  strobeReg;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sock_index_port u_dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .sockCfg(sockCfg),
    .sockStatus(sockStatus), .cardPresent(cardPresent), .rdStrobe(rdStrobe),
    .wrStrobe(wrStrobe), .strobeSock(strobeSock), .strobeReg(strobeReg)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cntOf(input logic [1:0] c);
    return (c == 2'b00) ? 2 : (c == 2'b01) ? 1 : 4;
  endfunction

  function automatic int pat(input int idx);
    return ((idx * 7) + 3) & 8'hFF;
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    @(negedge clk); rstN = 1'b1;
  endtask

  // Request held one cycle; registered results visible at the following negedge.
  task automatic hostWrite(input logic a, input logic [7:0] d);
    @(negedge clk); hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic a);
    @(negedge clk); hostRd = 1'b1; hostAddr = a;
    @(negedge clk); hostRd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R10: reset state
    check("R10 rdata", hostRdata, 0);
    check("R10 rdStrobe", rdStrobe, 0);
    check("R10 wrStrobe", wrStrobe, 0);
    hostRead(1'b0);
    check("R10 index", hostRdata, 0);
    hostRead(1'b1);
    check("R10 reg0", hostRdata, 0);

    // Sweep all indices under every configuration (R2, R3, R4, R5, R7, R8, R9)
    for (int c = 0; c < 4; c++) begin
      sockCfg = 2'(c);
      for (int s = 0; s < 4; s++) sockStatus[s*8 +: 8] = 8'(8'h40 + s * 8'h11 + c);
      doReset();
      for (int idx = 0; idx < 256; idx++) begin
        bit ok;
        ok = (idx / 64) < cntOf(2'(c));
        hostWrite(1'b0, 8'(idx));
        hostWrite(1'b1, 8'(pat(idx)));
        check("R9 wrStrobe", wrStrobe, ok ? 1 : 0);
        if (ok) begin
          check("R9 strobeSock", strobeSock, idx / 64);
          check("R9 strobeReg", strobeReg, idx % 64);
        end
        @(negedge clk);
        check("R9 wrStrobe one cycle", wrStrobe, 0);
      end
      for (int idx = 0; idx < 256; idx++) begin
        bit ok;
        int exp;
        ok = (idx / 64) < cntOf(2'(c));
        if (!ok)                 exp = 0;
        else if (idx % 64 == 1)  exp = sockStatus[(idx/64)*8 +: 8];
        else                     exp = pat(idx);
        hostWrite(1'b0, 8'(idx));
        hostRead(1'b1);
        if (!ok)                check("R4 unconfigured read", hostRdata, exp);
        else if (idx % 64 == 1) check("R7 status read", hostRdata, exp);
        else                    check("R2 data read", hostRdata, exp);
        check("R8 rdStrobe", rdStrobe, ok ? 1 : 0);
        if (ok) begin
          check("R8 strobeSock", strobeSock, idx / 64);
          check("R8 strobeReg", strobeReg, idx % 64);
        end
        @(negedge clk);
        check("R8 rdStrobe one cycle", rdStrobe, 0);
        hostRead(1'b0);
        check("R5 index kept", hostRdata, idx);
      end
    end

    // R4: writes under one-socket config are not stored in socket 1
    sockCfg = 2'b01;
    doReset();
    hostWrite(1'b0, 8'h45);
    hostWrite(1'b1, 8'h99);
    sockCfg = 2'b00;
    hostRead(1'b1);
    check("R4 ignored write", hostRdata, 0);

    // R3: socket count per configuration through cardPresent
    sockStatus = 32'hFFFF_FFFF;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); sockCfg = 2'(c); #1;
      check("R3 configured sockets", cardPresent, (1 << cntOf(2'(c))) - 1);
    end

    // R7: card present needs both bits 2 and 3 of socket 0
    sockCfg = 2'b10;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk); sockStatus[7:0] = 8'(8'hF3 | (b << 2)); #1;
      check("R7 card present", cardPresent[0], (b == 3) ? 1 : 0);
    end

    // R7: status register ignores writes
    hostWrite(1'b0, 8'h81);
    hostWrite(1'b1, 8'h00);
    sockStatus[23:16] = 8'h5A;
    hostRead(1'b1);
    check("R7 status not written", hostRdata, 8'h5A);

    // R6: 16-bit value as byte pair on socket 1
    doReset();
    hostWrite(1'b0, 8'h44); hostWrite(1'b1, 8'h34);
    hostWrite(1'b0, 8'h45); hostWrite(1'b1, 8'h12);
    for (int k = 8'h43; k <= 8'h46; k++) begin
      hostWrite(1'b0, 8'(k));
      hostRead(1'b1);
      check("R6 byte pair", hostRdata, (k == 8'h44) ? 8'h34 : (k == 8'h45) ? 8'h12 : 0);
    end

    // R11: write and read together -> write done, read dropped
    hostWrite(1'b0, 8'h0A);
    hostRead(1'b0);
    check("R11 setup", hostRdata, 8'h0A);
    @(negedge clk); hostWr = 1'b1; hostRd = 1'b1; hostAddr = 1'b1; hostWdata = 8'h77;
    @(negedge clk); hostWr = 1'b0; hostRd = 1'b0;
    check("R11 rdata held", hostRdata, 8'h0A);
    check("R11 no rdStrobe", rdStrobe, 0);
    check("R11 wrStrobe", wrStrobe, 1);
    hostRead(1'b1);
    check("R11 write done", hostRdata, 8'h77);

    // R1: index readback of an arbitrary value
    hostWrite(1'b0, 8'hC7);
    hostRead(1'b0);
    check("R1 index readback", hostRdata, 8'hC7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule